// File: doc/BRIEF.md
# Multi-Format Graphics Pixel Serializer

This block turns graphics-mode display memory into a stream of colour indices, one per clock. A row begins with a start pulse that captures the CRTC memory address and row address. For each character cell the block reads one 16-bit word, which holds two consecutive bytes, from a byte-addressed display memory. The row address picks an 8 KiB bank, which gives interleaved scan lines. The block unpacks the word in one of five pixel formats and passes every raw pixel value through a 16-entry, 4-bit palette register file. One more bit, the monochrome base select, sits above the palette result.

While a fetch-enable level stays high, cells follow each other with no gap. Each fetch is issued early enough that the next word is loaded on the same edge that retires the last pixel of the current cell. The format and the monochrome base are latched when a cell is loaded, so a cell is never rendered in a mix of two formats. The compatibility 2bpp format presets the first four palette entries to one of two fixed colour sets, chosen by a colour-select input.

Top module: `gfx_pixel_serializer`

## Requirements
- R1: The fetch byte address is `{row, (ma + col) mod 4096, 1'b0}`. The 2-bit row selects an 8 KiB bank, and the 13-bit offset is twice the 12-bit sum, wrapped. The memory answers on `mem_rdata` on the cycle after `mem_rd`. Bits [7:0] hold the first (even) byte and bits [15:8] hold the second byte.
- R2: After reset, `pix_valid` and `mem_rd` are low. A `row_start` sampled on an edge raises `mem_rd` on the next cycle, and the first pixel becomes valid after the third edge that follows the sampling edge. As long as `fetch_en` is high on the cycle that holds the third-last pixel of a cell, the next cell follows without a gap.
- R3: Format 3 (16-colour) gives 8 pixels per cell: first byte high nibble, first byte low nibble, second byte high nibble, second byte low nibble. Each nibble is output on two consecutive pixels.
- R4: Format 0 (packed 2bpp) gives 8 pixels per cell. The bit pairs are taken from 7..6 down to 1..0 of the first byte, then in the same way from the second byte.
- R5: Format 2 (planar 2bpp) gives 8 pixels, n running from 7 down to 0. For pixel n, bit n of the first byte is the low bit of the raw value and bit n of the second byte is the high bit.
- R6: Format 4 (1bpp) gives 16 pixels per cell: the first byte from bit 7 down to bit 0, then the second byte. A set bit takes palette entry 1 and a clear bit takes entry 0.
- R7: Each raw value indexes the palette, and `pix_index[3:0]` is the entry's content. At reset, entry i holds i. A write lands on a clock edge and is used by every pixel registered on a later edge.
- R8: Format 1 (compatibility 2bpp) decodes like format 0. Entries 0..3 are loaded with 0,A,C,E hex when `color_sel` is 0, or with 0,B,D,F when it is 1. The load happens on any cycle where `fmt_sel` is 1 and either `fmt_sel` or `color_sel` differs from its value on the previous cycle. The values held during reset count as 0.
- R9: A palette write and a preset that fall in the same cycle both take effect, and for the entry they share, the written value wins.
- R10: `fmt_sel` and `mono_sel` are sampled only on the edge that loads a cell. Changing either one part-way through a cell leaves the rest of that cell unchanged.
- R11: Format codes 5 to 7 make 8-slot cells with `pix_valid` low throughout. Fetching carries on as usual.
- R12: `pix_index[4]` is the latched monochrome base select of the cell being shown.
- R13: The column counter is set to 0 by `row_start` and goes up by one per fetch. The memory address plus the column wraps at 12 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| row_start | input | 1 | Starts a row: captures address and row, issues first fetch |
| fetch_en | input | 1 | Allows further cell fetches in the row |
| crtc_ma | input | 12 | CRTC memory address at row start |
| crtc_ra | input | 2 | CRTC row address (bank select) |
| fmt_sel | input | 3 | Pixel format code |
| mono_sel | input | 1 | Monochrome base select (bit 4 of output) |
| color_sel | input | 1 | Colour set for the compatibility preset |
| pal_we | input | 1 | Palette write strobe |
| pal_waddr | input | 4 | Palette entry to write |
| pal_wdata | input | 4 | Palette value |
| mem_rd | output | 1 | Display memory read request |
| mem_addr | output | 15 | Byte address of the first byte of the cell |
| mem_rdata | input | 16 | Two bytes returned the cycle after a request |
| pix_valid | output | 1 | Pixel strobe |
| pix_index | output | 5 | Colour index |

## Verification
Two pairs of functions can meet in the same cycle. The first is a palette write and a compatibility preset: the bench changes `color_sel` while format 1 is selected and, in that same cycle, writes entry 2. It then renders a format-1 row and expects the written value for entry 2 and preset values for the other entries. The second is a format or monochrome change and a cell load: the bench switches `fmt_sel` and `mono_sel` part-way through a cell. A behavioural reference model, run every clock, expects the old setting to last until the cell's final pixel and the new one to start with the next cell.

// File: rtl/gps_pkg.sv
// Package for the pixel serializer.
// Holds the format codes and pixel widths that the sub-blocks share.
// Assumes the format select is three bits wide. Codes above FMT_BIT1 are unused.
package gps_pkg;
    typedef logic [2:0] fmt_t;

    localparam fmt_t FMT_PACK2  = 3'd0;
    localparam fmt_t FMT_COMPAT2 = 3'd1;
    localparam fmt_t FMT_PLANE2 = 3'd2;
    localparam fmt_t FMT_NIB4   = 3'd3;
    localparam fmt_t FMT_BIT1   = 3'd4;

    localparam int RAW_W    = 4;   // raw pixel value width
    localparam int POS_W    = 4;   // pixel position counter width
    localparam int WORD_W   = 16;  // two bytes per cell
    localparam int NARROW_LAST = 7;
    localparam int WIDE_LAST   = 15;

    // True when the code names one of the five formats
    function automatic logic fmt_known(input fmt_t f);
        return f <= FMT_BIT1;
    endfunction

    // True when the format gives sixteen pixels per cell
    function automatic logic fmt_wide(input fmt_t f);
        return f == FMT_BIT1;
    endfunction
endpackage

// File: rtl/gps_fetch.sv
// Fetch sequencer.
// On row_start it captures the CRTC address and row, clears the column and
// requests the first word. After that, each want_fetch pulse requests the next column.
// pend marks the cycle in which mem_rdata carries the requested word.
// Assumes row_start comes only while no cell is being shown.
module gps_fetch #(
    parameter int MA_W = 12,
    parameter int RA_W = 2,
    localparam int ADDR_W = RA_W + MA_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              row_start,
    input  logic              want_fetch,
    input  logic [MA_W-1:0]   crtc_ma,
    input  logic [RA_W-1:0]   crtc_ra,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              pend
);
    logic [MA_W-1:0] base_ma;
    logic [MA_W-1:0] col;
    logic [RA_W-1:0] base_ra;

    // Builds the byte address: bank from row, doubled wrapped column offset
    function automatic logic [ADDR_W-1:0] byte_addr(input logic [RA_W-1:0] r,
                                                    input logic [MA_W-1:0] m,
                                                    input logic [MA_W-1:0] c);
        logic [MA_W-1:0] s;
        s = m + c;
        return {r, s, 1'b0};
    endfunction

    // Issue requests and track the returning word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_ma  <= '0;
            base_ra  <= '0;
            col      <= '0;
            mem_rd   <= 1'b0;
            mem_addr <= '0;
            pend     <= 1'b0;
        end else begin
            pend <= mem_rd;
            if (row_start) begin
                base_ma  <= crtc_ma;
                base_ra  <= crtc_ra;
                col      <= MA_W'(1);
                mem_addr <= byte_addr(crtc_ra, crtc_ma, '0);
                mem_rd   <= 1'b1;
            end else if (want_fetch) begin
                mem_addr <= byte_addr(base_ra, base_ma, col);
                col      <= col + MA_W'(1);
                mem_rd   <= 1'b1;
            end else begin
                mem_rd   <= 1'b0;
            end
        end
    end

    // Cell requests are spaced: the cell logic never asks on two cycles in a row
    assert_fetch_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        want_fetch |=> !want_fetch);
endmodule

// File: rtl/gps_palette.sv
// Palette register file.
// Holds ENTRIES values of VAL_W bits each, with a combinational read port for
// the pixel path. When the compatibility format is entered, or the colour set
// is changed while it is selected, the first PRESET_N entries are loaded with a
// fixed set. An explicit write in the same cycle takes priority.
// Assumes PRESET_N <= ENTRIES and VAL_W >= 4.
module gps_palette
    import gps_pkg::*;
#(
    parameter int ENTRIES  = 16,
    parameter int VAL_W    = 4,
    parameter int PRESET_N = 4,
    localparam int SEL_W   = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [SEL_W-1:0] waddr,
    input  logic [VAL_W-1:0] wdata,
    input  fmt_t             fmt_sel,
    input  logic             color_sel,
    input  logic [SEL_W-1:0] rd_idx,
    output logic [VAL_W-1:0] rd_val
);
    logic [VAL_W-1:0] regs [ENTRIES];
    fmt_t             prev_fmt;
    logic             prev_col;
    logic             preset;

    // Value loaded into entry i by the preset: 0 then even or odd bright colours
    function automatic logic [VAL_W-1:0] preset_val(input int i, input logic s);
        if (i == 0) return '0;
        return VAL_W'(2 * i + 8 + (s ? 1 : 0));
    endfunction

    // Detect entry into the compatibility format or a colour-set change within it
    always_comb begin
        preset = (fmt_sel == FMT_COMPAT2) &&
                 ((fmt_sel != prev_fmt) || (color_sel != prev_col));
    end

    // Update the entries: first the preset, then the explicit write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) regs[i] <= VAL_W'(i);
            prev_fmt <= FMT_PACK2;
            prev_col <= 1'b0;
        end else begin
            prev_fmt <= fmt_sel;
            prev_col <= color_sel;
            for (int i = 0; i < PRESET_N; i++) begin
                if (preset) regs[i] <= preset_val(i, color_sel);
            end
            if (we) regs[waddr] <= wdata;
        end
    end

    // Read port for the pixel path
    always_comb begin
        rd_val = regs[rd_idx];
    end

    // A written value is in place on the next cycle, even if a preset fired too
    assert_write_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> regs[$past(waddr)] == $past(wdata));

    // The preset loads entry 1 when no write to that entry collides with it
    assert_preset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (preset && !(we && waddr == SEL_W'(1))) |=> regs[1] == preset_val(1, $past(color_sel)));
endmodule

// File: rtl/gps_cell.sv
// Cell shifter and pixel decoder.
// When pend is high it loads the fetched word with the format and mono select
// of that moment, then steps one pixel per clock through 8 or 16 positions.
// For each position it produces the raw pixel value. It asks for the next word
// three pixels before the end of the cell, so the new word lands on the edge
// that retires the last pixel.
// Assumes the fetch path has two cycles of latency (request, then data).
module gps_cell
    import gps_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pend,
    input  logic [WORD_W-1:0] rdata,
    input  fmt_t              fmt_sel,
    input  logic              mono_sel,
    input  logic              fetch_en,
    output logic              want_fetch,
    output logic [RAW_W-1:0]  raw,
    output logic              cell_on,
    output logic              cell_mono
);
    logic              busy;
    logic [POS_W-1:0]  pos;
    logic [WORD_W-1:0] word;
    fmt_t              fmt_l;
    logic              mono_l;
    logic [POS_W-1:0]  last;
    logic [7:0]        lo_b;
    logic [7:0]        hi_b;
    logic [7:0]        pick;
    logic [7:0]        shf;

    // Position of the final pixel for the latched format
    always_comb begin
        last = fmt_wide(fmt_l) ? POS_W'(WIDE_LAST) : POS_W'(NARROW_LAST);
    end

    // Ask for the next word while the third-last pixel is shown
    always_comb begin
        want_fetch = busy && (pos == last - POS_W'(2)) && fetch_en;
    end

    // Load a cell or advance through it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            pos    <= '0;
            word   <= '0;
            fmt_l  <= FMT_PACK2;
            mono_l <= 1'b0;
        end else if (pend) begin
            busy   <= 1'b1;
            pos    <= '0;
            word   <= rdata;
            fmt_l  <= fmt_sel;
            mono_l <= mono_sel;
        end else if (busy) begin
            if (pos == last) busy <= 1'b0;
            else             pos  <= pos + POS_W'(1);
        end
    end

    // Pick the raw pixel for the current position in the latched format
    always_comb begin
        lo_b = word[7:0];
        hi_b = word[15:8];
        pick = '0;
        shf  = '0;
        raw  = '0;
        case (fmt_l)
            FMT_PACK2, FMT_COMPAT2: begin
                pick = pos[2] ? hi_b : lo_b;
                shf  = pick >> {~pos[1:0], 1'b0};
                raw  = {2'b00, shf[1:0]};
            end
            FMT_PLANE2: begin
                raw = {2'b00, hi_b[~pos[2:0]], lo_b[~pos[2:0]]};
            end
            FMT_NIB4: begin
                pick = pos[2] ? hi_b : lo_b;
                raw  = pos[1] ? pick[3:0] : pick[7:4];
            end
            FMT_BIT1: begin
                pick = pos[3] ? hi_b : lo_b;
                raw  = {3'b000, pick[~pos[2:0]]};
            end
            default: raw = '0;
        endcase
    end

    // Cell is visible only for a known format
    always_comb begin
        cell_on   = busy && fmt_known(fmt_l);
        cell_mono = mono_l;
    end

    // A new word never lands while a cell is mid-way
    assert_load_at_boundary_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && busy) |-> (pos == last));
endmodule

// File: rtl/gfx_pixel_serializer.sv
// Multi-format graphics pixel serializer, top level.
// Connects the fetch sequencer, the cell decoder and the palette, and registers
// the final colour index together with its valid strobe.
// Assumes a synchronous display memory that answers one cycle after mem_rd.
module gfx_pixel_serializer
    import gps_pkg::*;
#(
    parameter int MA_W    = 12,
    parameter int RA_W    = 2,
    parameter int PAL_N   = 16,
    parameter int PAL_W   = 4,
    localparam int ADDR_W = RA_W + MA_W + 1,
    localparam int SEL_W  = $clog2(PAL_N),
    localparam int OUT_W  = PAL_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              row_start,
    input  logic              fetch_en,
    input  logic [MA_W-1:0]   crtc_ma,
    input  logic [RA_W-1:0]   crtc_ra,
    input  logic [2:0]        fmt_sel,
    input  logic              mono_sel,
    input  logic              color_sel,
    input  logic              pal_we,
    input  logic [SEL_W-1:0]  pal_waddr,
    input  logic [PAL_W-1:0]  pal_wdata,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              pix_valid,
    output logic [OUT_W-1:0]  pix_index
);
    logic             want_fetch;
    logic             pend;
    logic [RAW_W-1:0] raw;
    logic             cell_on;
    logic             cell_mono;
    logic [PAL_W-1:0] pal_val;

    gps_fetch #(.MA_W(MA_W), .RA_W(RA_W)) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .row_start  (row_start),
        .want_fetch (want_fetch),
        .crtc_ma    (crtc_ma),
        .crtc_ra    (crtc_ra),
        .mem_rd     (mem_rd),
        .mem_addr   (mem_addr),
        .pend       (pend)
    );

    gps_cell u_cell (
        .clk        (clk),
        .rst_n      (rst_n),
        .pend       (pend),
        .rdata      (mem_rdata),
        .fmt_sel    (fmt_sel),
        .mono_sel   (mono_sel),
        .fetch_en   (fetch_en),
        .want_fetch (want_fetch),
        .raw        (raw),
        .cell_on    (cell_on),
        .cell_mono  (cell_mono)
    );

    gps_palette #(.ENTRIES(PAL_N), .VAL_W(PAL_W), .PRESET_N(4)) u_pal (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (pal_we),
        .waddr     (pal_waddr),
        .wdata     (pal_wdata),
        .fmt_sel   (fmt_sel),
        .color_sel (color_sel),
        .rd_idx    (SEL_W'(raw)),
        .rd_val    (pal_val)
    );

    // Register the colour index with the mono base on top
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_valid <= 1'b0;
            pix_index <= '0;
        end else begin
            pix_valid <= cell_on;
            pix_index <= cell_on ? {cell_mono, pal_val} : '0;
        end
    end

    // A row start always issues a memory request on the next cycle
    assert_row_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        row_start |=> mem_rd);
endmodule

// File: tb/gfx_pixel_serializer_bench.sv
module gfx_pixel_serializer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        row_start = 1'b0;
    logic        fetch_en = 1'b0;
    logic [11:0] crtc_ma = '0;
    logic [1:0]  crtc_ra = '0;
    logic [2:0]  fmt_sel = '0;
    logic        mono_sel = 1'b0;
    logic        color_sel = 1'b0;
    logic        pal_we = 1'b0;
    logic [3:0]  pal_waddr = '0;
    logic [3:0]  pal_wdata = '0;
    logic        mem_rd;
    logic [14:0] mem_addr;
    logic [15:0] mem_rdata = '0;
    logic        pix_valid;
    logic [4:0]  pix_index;

    int errors = 0;
    int checks = 0;
    string phase = "reset";

    always #5 clk = ~clk;

    gfx_pixel_serializer u_gfx_pixel_serializer (
        .clk(clk), .rst_n(rst_n), .row_start(row_start), .fetch_en(fetch_en),
        .crtc_ma(crtc_ma), .crtc_ra(crtc_ra), .fmt_sel(fmt_sel), .mono_sel(mono_sel),
        .color_sel(color_sel), .pal_we(pal_we), .pal_waddr(pal_waddr), .pal_wdata(pal_wdata),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .pix_valid(pix_valid), .pix_index(pix_index)
    );

    // Display memory content is a fixed function of the byte address
    function automatic int memf(input int a);
        return ((a * 29) ^ (a >> 5)) & 255;
    endfunction

    // Synchronous memory: data the cycle after the request
    always @(posedge clk) begin
        if (mem_rd)
            mem_rdata <= {8'(memf(int'(mem_addr) + 1)), 8'(memf(int'(mem_addr)))};
    end

    function automatic int raw_of(input int w, input int f, input int p);
        int b0, b1, bt;
        b0 = w & 255;
        b1 = (w >> 8) & 255;
        case (f)
            0, 1: begin bt = (p < 4) ? b0 : b1; return (bt >> (6 - 2 * (p % 4))) & 3; end
            2: return (((b1 >> (7 - p)) & 1) << 1) | ((b0 >> (7 - p)) & 1);
            3: begin bt = (p < 4) ? b0 : b1; return ((p / 2) % 2 == 0) ? (bt >> 4) & 15 : bt & 15; end
            4: begin bt = (p < 8) ? b0 : b1; return (bt >> (7 - (p % 8))) & 1; end
            default: return 0;
        endcase
    endfunction

    function automatic string fmt_tag(input int f);
        case (f)
            0: return "R4";
            1: return "R8";
            2: return "R5";
            3: return "R3";
            4: return "R6";
            default: return "R11";
        endcase
    endfunction

    function automatic int mk(input int r, input int m, input int c);
        return (r << 13) | (((m + c) % 4096) * 2);
    endfunction

    // Behavioural reference model, advanced on every rising edge
    int pal_m [16];
    int m_busy, m_pos, m_word, m_fmt, m_mono;
    int m_f1, m_addr, m_pend, m_pw, m_bma, m_bra, m_col;
    int prev_fmt, prev_col;
    int exp_v, exp_i;
    string exp_tag = "R2";

    always @(posedge clk) begin
        int lastm, want, npend, nword, pre;
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) pal_m[i] = i;
            m_busy = 0; m_pos = 0; m_word = 0; m_fmt = 0; m_mono = 0;
            m_f1 = 0; m_addr = 0; m_pend = 0; m_pw = 0; m_bma = 0; m_bra = 0; m_col = 0;
            prev_fmt = 0; prev_col = 0; exp_v = 0; exp_i = 0;
        end else begin
            lastm = (m_fmt == 4) ? 15 : 7;
            exp_v = (m_busy != 0 && m_fmt < 5) ? 1 : 0;
            exp_tag = {phase, "/", fmt_tag(m_fmt)};
            if (exp_v != 0) exp_i = m_mono * 16 + pal_m[raw_of(m_word, m_fmt, m_pos)];
            want = (m_busy != 0 && m_pos == lastm - 2 && fetch_en) ? 1 : 0;
            npend = m_f1;
            nword = memf(m_addr) | (memf(m_addr + 1) << 8);
            if (row_start) begin
                m_f1 = 1; m_addr = mk(crtc_ra, crtc_ma, 0);
                m_bma = crtc_ma; m_bra = crtc_ra; m_col = 1;
            end else if (want != 0) begin
                m_f1 = 1; m_addr = mk(m_bra, m_bma, m_col); m_col = m_col + 1;
            end else m_f1 = 0;
            if (m_pend != 0) begin
                m_word = m_pw; m_fmt = fmt_sel; m_mono = mono_sel; m_pos = 0; m_busy = 1;
            end else if (m_busy != 0) begin
                if (m_pos == lastm) m_busy = 0; else m_pos = m_pos + 1;
            end
            m_pend = npend; m_pw = nword;
            pre = (fmt_sel == 1 && (fmt_sel != prev_fmt || color_sel != prev_col)) ? 1 : 0;
            if (pre != 0) begin
                pal_m[0] = 0;
                for (int k = 1; k < 4; k++) pal_m[k] = 8 + 2 * k + color_sel;
            end
            if (pal_we) pal_m[pal_waddr] = pal_wdata;
            prev_fmt = fmt_sel; prev_col = color_sel;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compare against the model away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk(pix_valid == exp_v[0], exp_tag, "pix_valid", pix_valid, exp_v);
            if (exp_v != 0) chk(pix_index == 5'(exp_i), exp_tag, "pix_index", pix_index, exp_i);
            chk(mem_rd == m_f1[0], "R2", "mem_rd", mem_rd, m_f1);
            if (m_f1 != 0) chk(mem_addr == 15'(m_addr), "R1 R13", "mem_addr", mem_addr, m_addr);
        end
    end

    task automatic pal_wr(input int a, input int d);
        @(negedge clk);
        pal_we = 1'b1; pal_waddr = 4'(a); pal_wdata = 4'(d);
        @(negedge clk);
        pal_we = 1'b0;
    endtask

    task automatic run_row(input int ma, input int ra, input int n, input bit lat);
        @(negedge clk);
        row_start = 1'b1; fetch_en = 1'b1; crtc_ma = 12'(ma); crtc_ra = 2'(ra);
        @(negedge clk);
        row_start = 1'b0;
        if (lat) chk(mem_rd == 1'b1, "R2", "request after row start", mem_rd, 1);
        @(negedge clk);
        @(negedge clk);
        if (lat) chk(pix_valid == 1'b0, "R2", "no pixel before third edge", pix_valid, 0);
        @(negedge clk);
        if (lat) chk(pix_valid == 1'b1, "R2", "first pixel on third edge", pix_valid, 1);
        repeat (n) @(negedge clk);
        fetch_en = 1'b0;
        repeat (40) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(pix_valid == 1'b0, "R2", "reset pix_valid", pix_valid, 0);
        chk(mem_rd == 1'b0, "R2", "reset mem_rd", mem_rd, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        phase = "R4 R7"; fmt_sel = 3'd0;
        run_row(100, 0, 30, 1'b1);

        phase = "R7";
        for (int i = 0; i < 16; i++) pal_wr(i, (i * 7 + 3) & 15);
        fmt_sel = 3'd2;
        run_row(200, 1, 30, 1'b0);

        phase = "R3 R12"; fmt_sel = 3'd3; mono_sel = 1'b1;
        run_row(300, 2, 30, 1'b0);

        phase = "R6"; fmt_sel = 3'd4; mono_sel = 1'b0;
        pal_wr(0, 9); pal_wr(1, 6);
        run_row(400, 3, 50, 1'b0);

        phase = "R8"; color_sel = 1'b0; fmt_sel = 3'd1;
        run_row(500, 0, 30, 1'b0);
        color_sel = 1'b1;
        run_row(600, 1, 30, 1'b0);

        phase = "R9";
        @(negedge clk);
        color_sel = 1'b0; pal_we = 1'b1; pal_waddr = 4'd2; pal_wdata = 4'd5;
        @(negedge clk);
        pal_we = 1'b0;
        run_row(700, 2, 30, 1'b0);

        phase = "R11"; fmt_sel = 3'd6;
        run_row(800, 3, 30, 1'b0);

        phase = "R10"; fmt_sel = 3'd0; mono_sel = 1'b0;
        @(negedge clk);
        row_start = 1'b1; fetch_en = 1'b1; crtc_ma = 12'd900; crtc_ra = 2'd1;
        @(negedge clk);
        row_start = 1'b0;
        repeat (6) @(negedge clk);
        fmt_sel = 3'd3; mono_sel = 1'b1;
        repeat (13) @(negedge clk);
        fmt_sel = 3'd4;
        repeat (20) @(negedge clk);
        fetch_en = 1'b0;
        repeat (40) @(negedge clk);

        phase = "R13"; fmt_sel = 3'd0; mono_sel = 1'b0;
        run_row(4094, 3, 30, 1'b0);

        phase = "R12"; fmt_sel = 3'd2;
        @(negedge clk);
        row_start = 1'b1; fetch_en = 1'b1; crtc_ma = 12'd50; crtc_ra = 2'd0;
        @(negedge clk);
        row_start = 1'b0;
        repeat (9) @(negedge clk);
        mono_sel = 1'b1;
        repeat (11) @(negedge clk);
        mono_sel = 1'b0;
        repeat (10) @(negedge clk);
        fetch_en = 1'b0;
        repeat (40) @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule